// File: doc/BRIEF.md
# Configurable SPI master shift engine

This block moves one data word at a time across an SPI link as the bus master. A word offered on a ready/valid transmit input is loaded into a shift register. The frame (chip-select) line is asserted, a serial clock derived from the system clock is toggled, the word goes out on MOSI, and a word of the same length is collected from MISO. The collected word is handed back on a ready/valid receive output. A busy flag is high for as long as a word is in flight.

The bus timing is not chosen by a CPOL/CPHA pair. It is set by four independent controls: the clock idle level, the edge on which MISO is sampled, an optional lead-in delay before the first clock transition, and the frame-start edge, which sets the length of that delay. Three more controls set the frame polarity, the bit order and the word length. An enable input gates the whole engine, and dropping it aborts a word in progress. The FIFOs, the register interface and the interrupts sit outside this block.

Top module: `spi_shift_engine`

## Requirements
- R1: A transmit word is accepted on a clock edge where tx_valid and tx_ready are both high. tx_ready is high only when enable is high, busy is low and no received word is waiting. From the next cycle, busy is high and frame is at its active level.
- R2: While busy is low, sclk equals idle_level and frame equals the inverse of frame_pol. A finished word makes exactly 2·N transitions on sclk, where N is the effective word length, and sclk ends at idle_level before busy falls.
- R3: Consecutive sclk transitions are H system clocks apart. H is clk_ratio/2, and a ratio below 2 gives H = 1.
- R4: The first sclk transition comes D + H clocks after frame asserts. D is 0 when clk_delay = 0, 2·H when clk_delay = 1 and start_fall = 0, and H when clk_delay = 1 and start_fall = 1.
- R5: MISO is sampled on rising sclk transitions when capture_fall = 0 and on falling ones when capture_fall = 1. MOSI moves to its next bit only on the opposite transitions, and the first bit is present from frame assertion. A slave that samples on the same edge and launches on the other receives the transmit word intact.
- R6: With lsb_first = 0, bit N-1 of the word goes first in both directions. With lsb_first = 1, bit 0 goes first. The received word is right-aligned in rx_data, and the bits above N are zero.
- R7: word_len gives N for values 1 to MAXW (default MAXW = 32). A value of 0, or one above MAXW, gives N = MAXW.
- R8: rx_valid rises on the same clock edge as the sclk transition that samples the last bit. It then stays high with rx_data unchanged until a cycle with rx_ready high.
- R9: If enable is low at a clock edge, busy is low from the next cycle. sclk returns to idle_level and frame is released. An aborted word never produces rx_valid.
- R10: frame_pol gives the active level of frame, for both polarity settings.
- R11: Each of the four standard control sets completes a word correctly. The sets are given as (capture_fall, idle_level, clk_delay, start_fall): mode 0 = (1,0,1,0), mode 1 = (0,0,0,1), mode 2 = (0,1,1,1), mode 3 = (1,1,0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low aborts and holds idle |
| clk_ratio | input | RW | Serial clock divider ratio (even) |
| idle_level | input | 1 | SCLK level between words |
| capture_fall | input | 1 | 0: sample MISO on rising SCLK, 1: on falling |
| clk_delay | input | 1 | Insert lead-in before the first SCLK transition |
| start_fall | input | 1 | Frame-start edge; selects half (1) or full (0) period lead-in |
| frame_pol | input | 1 | Active level of the frame line |
| lsb_first | input | 1 | Bit order, 1 = least significant bit first |
| word_len | input | 6 | Word length in bits |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can accept a transmit word |
| tx_data | input | MAXW | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Receiver takes the word |
| rx_data | output | MAXW | Received word, right-aligned |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| frame | output | 1 | Chip-select line |
| busy | output | 1 | Word on the wire |

## Verification
A wrong timer or edge counter shows first at sclk. The lead-in or the transition spacing drifts from D + H and H by the first transition, or the word ends after the wrong number of transitions, and the bench's slave model counts this within one word. A wrong shift direction or capture edge leaves the word on the wire bit-reversed or off by one position. This shows when the slave's captured word and rx_data are compared at the end of the word. A stuck busy or a lost rx_valid handshake shows as tx_ready staying low, or rx_data changing, in the cycles right after the word.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int MAXW = 32,
  parameter int RW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [RW-1:0]   clk_ratio,
  input  logic            idle_level,
  input  logic            capture_fall,
  input  logic            clk_delay,
  input  logic            start_fall,
  input  logic            frame_pol,
  input  logic            lsb_first,
  input  logic [5:0]      word_len,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [MAXW-1:0] tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [MAXW-1:0] rx_data,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            frame,
  output logic            busy
);
  localparam int CW = RW + 1;
  localparam int EW = $clog2(2 * MAXW + 1);
  localparam int IW = $clog2(MAXW);

  logic [CW-1:0]   cnt, half, lead;
  logic [EW-1:0]   edges, caps, eff_len, last_edge;
  logic [IW-1:0]   top_idx;
  logic [MAXW-1:0] sh_tx, sh_rx, rx_next;
  logic            busy_r, sclk_r, new_sclk, cap_edge, accept;

  assign half      = (clk_ratio < RW'(2)) ? CW'(1) : CW'(clk_ratio >> 1);
  assign lead      = !clk_delay ? '0 : (start_fall ? half : (half << 1));
  assign eff_len   = (word_len == 6'd0 || 32'(word_len) > MAXW) ? EW'(MAXW) : EW'(word_len);
  assign last_edge = eff_len << 1;
  assign top_idx   = IW'(eff_len - EW'(1));
  assign new_sclk  = ~sclk_r;
  assign cap_edge  = new_sclk ^ capture_fall;
  assign rx_next   = lsb_first ? ((sh_rx >> 1) | (MAXW'(miso) << top_idx))
                               : {sh_rx[MAXW-2:0], miso};

  assign tx_ready = enable & ~busy_r & ~rx_valid;
  assign accept   = tx_valid & tx_ready;
  assign busy     = busy_r;
  assign sclk     = busy_r ? sclk_r : idle_level;
  assign frame    = busy_r ? frame_pol : ~frame_pol;
  assign mosi     = busy_r & (lsb_first ? sh_tx[0] : sh_tx[top_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r   <= 1'b0;
      sclk_r   <= 1'b0;
      cnt      <= '0;
      edges    <= '0;
      caps     <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (!enable) begin
        busy_r <= 1'b0;
      end else if (accept) begin
        busy_r <= 1'b1;
        sclk_r <= idle_level;
        cnt    <= lead + half - CW'(1);
        edges  <= '0;
        caps   <= '0;
        sh_tx  <= tx_data;
        sh_rx  <= '0;
      end else if (busy_r) begin
        if (cnt != '0) begin
          cnt <= cnt - CW'(1);
        end else if (edges == last_edge) begin
          busy_r <= 1'b0;
        end else begin
          sclk_r <= new_sclk;
          edges  <= edges + EW'(1);
          cnt    <= half - CW'(1);
          if (cap_edge) begin
            sh_rx <= rx_next;
            caps  <= caps + EW'(1);
            if (caps + EW'(1) == eff_len) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_next;
            end
          end else if (caps != '0) begin
            sh_tx <= lsb_first ? (sh_tx >> 1) : (sh_tx << 1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int MAXW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            frame_pol,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [MAXW-1:0] rx_data,
  input logic            sclk,
  input logic            frame,
  input logic            busy
);
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready) |=> busy); // R1
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !tx_ready); // R1
  AST_END_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy) && $past(enable)) |-> $stable(sclk)); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R8
  AST_RX_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_valid) |-> !$stable(sclk)); // R8
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !busy); // R9
  AST_FRAME_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready) |=> (frame == frame_pol)); // R10
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.MAXW(MAXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .frame_pol(frame_pol),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .sclk(sclk), .frame(frame), .busy(busy)
);

// File: tb/spi_shift_engine_bench.sv
`timescale 1ns/1ps
module spi_shift_engine_bench;
  logic        clk = 0, rst_n = 0, enable = 0;
  logic [7:0]  clk_ratio = 8'd4;
  logic        idle_level = 0, capture_fall = 0, clk_delay = 0, start_fall = 0;
  logic        frame_pol = 0, lsb_first = 0;
  logic [5:0]  word_len = 6'd8;
  logic        tx_valid = 0, rx_ready = 1;
  logic [31:0] tx_data = 0;
  logic        tx_ready, rx_valid, sclk, mosi, frame, busy, miso;
  logic [31:0] rx_data;

  int tests = 0, fails = 0, cyc = 0;

  spi_shift_engine u_spi_shift_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_ratio(clk_ratio),
    .idle_level(idle_level), .capture_fall(capture_fall), .clk_delay(clk_delay),
    .start_fall(start_fall), .frame_pol(frame_pol), .lsb_first(lsb_first),
    .word_len(word_len), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .miso(miso),
    .sclk(sclk), .mosi(mosi), .frame(frame), .busy(busy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // slave model
  int          sl_len = 8, sl_idx = 0, sl_caps = 0, edge_cnt = 0;
  int          fcnt = 0, first_delay = 0, gap = 0, exp_h = 2;
  bit          sl_lsb = 0, in_frame = 0, gap_bad = 0, rx_at_last = 0, prev_rxv = 0;
  logic        prev_sclk = 0;
  logic [31:0] sl_word = 0, got_mosi = 0;

  function automatic int bpos(input int k);
    return sl_lsb ? k : sl_len - 1 - k;
  endfunction

  assign miso = (sl_idx < sl_len) ? sl_word[bpos(sl_idx)] : 1'b0;

  always @(negedge clk) begin
    if (rst_n && frame == frame_pol) begin
      if (!in_frame) begin
        in_frame = 1; sl_idx = 0; sl_caps = 0; edge_cnt = 0; got_mosi = 0;
        fcnt = 0; gap = 0; gap_bad = 0; rx_at_last = 0;
      end else begin
        fcnt = fcnt + 1;
        gap  = gap + 1;
        if (sclk != prev_sclk) begin
          edge_cnt = edge_cnt + 1;
          if (edge_cnt == 1) first_delay = fcnt;
          else if (gap != exp_h) gap_bad = 1;
          gap = 0;
          if (sclk == !capture_fall) begin
            if (sl_caps < sl_len) got_mosi[bpos(sl_caps)] = mosi;
            sl_caps = sl_caps + 1;
            if (sl_caps == sl_len) rx_at_last = rx_valid && !prev_rxv;
          end else if (sl_caps > 0) begin
            sl_idx = sl_idx + 1;
          end
        end
      end
    end else begin
      in_frame = 0;
    end
    prev_sclk = sclk;
    prev_rxv  = rx_valid;
  end

  task automatic set_mode(input int m);
    case (m)
      0: begin capture_fall = 1; idle_level = 0; clk_delay = 1; start_fall = 0; end
      1: begin capture_fall = 0; idle_level = 0; clk_delay = 0; start_fall = 1; end
      2: begin capture_fall = 0; idle_level = 1; clk_delay = 1; start_fall = 1; end
      default: begin capture_fall = 1; idle_level = 1; clk_delay = 0; start_fall = 0; end
    endcase
  endtask

  logic [31:0] got_rx;

  task automatic xfer(input int len, input bit lsb, input logic [31:0] mword,
                      input logic [31:0] sword, input string tag);
    int L;
    logic [31:0] mask;
    L = (len == 0 || len > 32) ? 32 : len;
    mask = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 1);
    @(negedge clk);
    word_len = 6'(len); lsb_first = lsb; sl_lsb = lsb; sl_len = L;
    sl_word = sword & mask; tx_data = mword & mask;
    exp_h = (clk_ratio < 2) ? 1 : int'(clk_ratio) / 2;
    tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    check(busy == 1 && frame == frame_pol, {tag, " R1 start"}, {busy, frame}, {1'b1, frame_pol});
    while (!rx_valid) @(negedge clk);
    got_rx = rx_data;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(got_mosi == (mword & mask), {tag, " R5 R6 mosi word"}, got_mosi, mword & mask);
    check(got_rx == (sword & mask), {tag, " R6 rx word"}, got_rx, sword & mask);
    check(edge_cnt == 2 * L, {tag, " R2 R7 edge count"}, edge_cnt, 2 * L);
    check(sclk == idle_level && frame == !frame_pol, {tag, " R2 idle after"}, {sclk, frame}, {idle_level, !frame_pol});
    check(!gap_bad, {tag, " R3 spacing"}, gap_bad, 0);
    check(rx_at_last, {tag, " R8 rx with last edge"}, rx_at_last, 1);
  endtask

  task automatic t_reset;
    check(busy == 0 && rx_valid == 0 && tx_ready == 1, "R1 reset state", {busy, rx_valid, tx_ready}, 3'b001);
    check(sclk == idle_level && frame == !frame_pol, "R2 reset lines", {sclk, frame}, {idle_level, !frame_pol});
  endtask

  task automatic t_modes;
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      clk_ratio = 8'd4;
      xfer(8, 0, 32'hA5 ^ m, 32'h3C + m, $sformatf("R11 mode%0d", m));
    end
  endtask

  task automatic t_delay;
    int expd;
    clk_ratio = 8'd4;
    set_mode(0);
    xfer(8, 0, 32'h5A, 32'hC3, "R4 full delay");
    expd = 3 * 2;
    check(first_delay == expd, "R4 lead full period", first_delay, expd);
    set_mode(2);
    xfer(8, 0, 32'h12, 32'h34, "R4 half delay");
    expd = 2 * 2;
    check(first_delay == expd, "R4 lead half period", first_delay, expd);
    set_mode(3);
    xfer(8, 0, 32'h56, 32'h78, "R4 no delay");
    expd = 2;
    check(first_delay == expd, "R4 lead none", first_delay, expd);
  endtask

  task automatic t_ratio;
    set_mode(1);
    clk_ratio = 8'd10;
    xfer(8, 0, 32'h96, 32'h69, "R3 ratio10");
    check(first_delay == 5, "R3 ratio10 first", first_delay, 5);
    clk_ratio = 8'd2;
    xfer(8, 1, 32'hE1, 32'h1E, "R3 ratio2");
    clk_ratio = 8'd4;
  endtask

  task automatic t_order_len;
    set_mode(0);
    xfer(8, 1, 32'h01, 32'h80, "R6 lsb first");
    xfer(5, 0, 32'h13, 32'h0A, "R7 len5");
    xfer(16, 1, 32'hBEEF, 32'h1234, "R7 len16");
    xfer(0, 0, 32'hDEADBEEF, 32'h8000_0001, "R7 len0 is max");
  endtask

  task automatic t_polarity;
    frame_pol = 1;
    set_mode(3);
    @(negedge clk);
    check(frame == 0, "R10 released low", frame, 0);
    xfer(8, 0, 32'hC7, 32'h7C, "R10 active high");
    frame_pol = 0;
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    set_mode(1);
    rx_ready = 0;
    xfer(8, 0, 32'h0F, 32'hF0, "R8 backpressure");
    held = rx_data;
    check(rx_valid == 1 && tx_ready == 0, "R1 R8 pending blocks", {rx_valid, tx_ready}, 2'b10);
    repeat (10) @(negedge clk);
    check(rx_valid == 1 && rx_data == held, "R8 held stable", rx_data, held);
    rx_ready = 1;
    @(negedge clk);
    check(rx_valid == 0 && tx_ready == 1, "R8 released", {rx_valid, tx_ready}, 2'b01);
  endtask

  task automatic t_abort;
    set_mode(2);
    clk_ratio = 8'd8;
    @(negedge clk);
    word_len = 6'd8; tx_data = 32'hAA; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    repeat (20) @(negedge clk);
    check(busy == 1, "R9 mid word", busy, 1);
    enable = 0;
    @(negedge clk);
    check(busy == 0 && sclk == idle_level && frame == !frame_pol, "R9 abort lines",
          {busy, sclk, frame}, {1'b0, idle_level, !frame_pol});
    check(tx_ready == 0, "R9 not ready while disabled", tx_ready, 0);
    repeat (60) @(negedge clk);
    check(rx_valid == 0, "R9 no rx after abort", rx_valid, 0);
    enable = 1;
    clk_ratio = 8'd4;
    xfer(8, 0, 32'h3A, 32'hA3, "R9 after abort");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    enable = 1;
    @(negedge clk);
    t_reset;
    t_modes;
    t_delay;
    t_ratio;
    t_order_len;
    t_polarity;
    t_backpressure;
    t_abort;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule